// File: doc/BRIEF.md
# Packed Default-Attribute Register Loader

This block listens on a register-write bus and assembles four 24-bit component values from three consecutive 32-bit data writes. The components are packed back to back inside the 96 bits of the three words, with the last component first. Once the third word lands, the block unpacks the vector and stores it as raw bit patterns into a sixteen-entry attribute memory. The slot is chosen by an index register. The index steps forward after every stored vector, so a stream of triples fills consecutive slots.

Software writes the index register to pick a starting slot, then streams the packed words to any of the three data addresses. A vector that completes while the index is outside the memory is dropped, and a one-cycle error pulse reports it. A read port exposes any slot's four components, and the current index is visible on an output.

Top module: `attr_pack_loader`

## Requirements
- R1: A write to any of the data addresses 0x233, 0x234 or 0x235 is taken as the next packed word. Words are collected in arrival order, whatever mix of the three addresses is used.
- R2: The third collected word completes a vector, and the word count returns to zero. The next write to a data address then starts a new vector.
- R3: Component w is bits [31:8] of the first word.
- R4: Component z is bits [7:0] of the first word as its upper byte, followed by bits [31:16] of the second word.
- R5: Component y is bits [15:0] of the second word as its upper part, followed by bits [31:24] of the third word.
- R6: Component x is bits [23:0] of the third word. It is readable on the read port right after the clock edge that accepts the third word.
- R7: The memory has 16 slots. A vector that completes while the index is 16 or higher is discarded, and err_o is high for exactly the one cycle after that edge.
- R8: After a vector is stored, the index rises by one.
- R9: A rejected vector leaves the index and every memory slot unchanged, and it still clears the word count.
- R10: A write to address 0x232 loads the index from wr_data[4:0] and clears any partly collected vector.
- R11: Writes to any other address have no effect, and so does a cycle with wr_en low.
- R12: A synchronous reset clears every slot to zero, the index to 0, the word count and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Register address |
| wr_data | input | 32 | Write data |
| slot_idx | output | 5 | Current index register |
| err_o | output | 1 | Out-of-range rejection pulse |
| rd_slot | input | 4 | Slot selected for readback |
| rd_x | output | 24 | Component x of the selected slot |
| rd_y | output | 24 | Component y of the selected slot |
| rd_z | output | 24 | Component z of the selected slot |
| rd_w | output | 24 | Component w of the selected slot |

## Verification
The bench builds the block with its default parameters: 16 slots, a 5-bit index, and the data and index addresses at 0x233 and 0x232. With a 5-bit index, a value of 16 or more can be loaded directly. That makes the rejection path reachable right after slot 15 fills, and again through a direct write of an out-of-range index. Sixteen slots stay small enough that the bench reads every one of them back after reset and after each rejection.

// File: rtl/attr_pack_loader.sv
module attr_pack_loader #(
  parameter int ADDR_W = 12,
  parameter int SLOTS = 16,
  parameter int IDX_W = 5,
  parameter logic [ADDR_W-1:0] DATA_BASE = 12'h233,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 12'h232
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              err_o,
  input  logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic [23:0]       rd_x,
  output logic [23:0]       rd_y,
  output logic [23:0]       rd_z,
  output logic [23:0]       rd_w
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int VEC_W = 4 * 24;

  logic [1:0]       cnt;
  logic [31:0]      word0, word1;
  logic [VEC_W-1:0] mem [SLOTS];

  wire data_hit = wr_en && (wr_addr >= DATA_BASE) && (wr_addr <= DATA_BASE + ADDR_W'(2));
  wire idx_hit  = wr_en && (wr_addr == IDX_ADDR);
  wire complete = data_hit && (cnt == 2'd2);
  wire slot_ok  = (slot_idx < IDX_W'(SLOTS));

  wire [23:0] new_w = word0[31:8];
  wire [23:0] new_z = {word0[7:0], word1[31:16]};
  wire [23:0] new_y = {word1[15:0], wr_data[31:24]};
  wire [23:0] new_x = wr_data[23:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      word0 <= '0;
      word1 <= '0;
      slot_idx <= '0;
      err_o <= 1'b0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      err_o <= 1'b0;
      if (idx_hit) begin
        slot_idx <= wr_data[IDX_W-1:0];
        cnt <= '0;
      end else if (complete) begin
        cnt <= '0;
        if (slot_ok) begin
          mem[slot_idx[SLOT_W-1:0]] <= {new_w, new_z, new_y, new_x};
          slot_idx <= slot_idx + 1'b1;
        end else begin
          err_o <= 1'b1;
        end
      end else if (data_hit) begin
        if (cnt == 2'd0) word0 <= wr_data;
        else word1 <= wr_data;
        cnt <= cnt + 2'd1;
      end
    end
  end

  assign {rd_w, rd_z, rd_y, rd_x} = mem[rd_slot];

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt != 2'd3);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    complete |=> cnt == 2'd0);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (complete && !slot_ok) |=> err_o && slot_idx == $past(slot_idx));

  assert_idx_step_R8: assert property (@(posedge clk) disable iff (rst)
    (complete && slot_ok) |=> !err_o && slot_idx == $past(slot_idx) + 1'b1);

  assert_idx_load_R10: assert property (@(posedge clk) disable iff (rst)
    idx_hit |=> cnt == 2'd0 && slot_idx == $past(wr_data[IDX_W-1:0]));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cnt) && $stable(slot_idx) && !err_o);
endmodule

// File: tb/test_attr_pack_loader.sv
module test_attr_pack_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  slot_idx;
  logic        err_o;
  logic [3:0]  rd_slot = '0;
  logic [23:0] rd_x, rd_y, rd_z, rd_w;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  attr_pack_loader i_attr_pack_loader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slot_idx(slot_idx), .err_o(err_o), .rd_slot(rd_slot),
    .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z), .rd_w(rd_w)
  );

  // words of each vector, then expected x, y, z, w worked out from R3..R6
  localparam logic [31:0] TW [4][3] = '{
    '{32'h11223344, 32'h55667788, 32'h99AABBCC},
    '{32'hFFFFFF00, 32'h0000FFFF, 32'h00FFFFFF},
    '{32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF},
    '{32'h00000000, 32'h00000000, 32'h00000001}
  };
  localparam logic [23:0] TE [4][4] = '{
    '{24'hAABBCC, 24'h778899, 24'h445566, 24'h112233},
    '{24'hFFFFFF, 24'hFFFF00, 24'h000000, 24'hFFFFFF},
    '{24'hABCDEF, 24'h456789, 24'hEF0123, 24'hDEADBE},
    '{24'h000001, 24'h000000, 24'h000000, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_slot(input string req, input int s, input logic [23:0] x,
                          input logic [23:0] y, input logic [23:0] z, input logic [23:0] w);
    rd_slot = 4'(s);
    #1;
    chk({req, " x"}, 32'(rd_x), 32'(x));
    chk({req, " y"}, 32'(rd_y), 32'(y));
    chk({req, " z"}, 32'(rd_z), 32'(z));
    chk({req, " w"}, 32'(rd_w), 32'(w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk("R12 idx", 32'(slot_idx), 0);
    chk("R12 err", 32'(err_o), 0);
    for (int s = 0; s < 16; s++) chk_slot("R12", s, 0, 0, 0, 0);

    // R1, R3..R6, R8: table walk, address mix varies per entry
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 3; j++) wr(12'h233 + 12'((k + j) % 3), TW[k][j]);
      chk("R7 no err", 32'(err_o), 0);
      chk("R8 idx", 32'(slot_idx), 32'(k + 1));
      chk_slot("R1 R3 R4 R5 R6", k, TE[k][0], TE[k][1], TE[k][2], TE[k][3]);
    end

    // R10: a partial word is dropped by an index write
    wr(12'h233, 32'hCAFEF00D);
    wr(12'h232, 32'd9);
    chk("R10 idx", 32'(slot_idx), 9);
    for (int j = 0; j < 3; j++) wr(12'h234, TW[2][j]);
    chk_slot("R10 slot", 9, TE[2][0], TE[2][1], TE[2][2], TE[2][3]);
    chk("R8 idx after 9", 32'(slot_idx), 10);

    // R11: foreign addresses and idle cycles do not disturb collection
    wr(12'h233, TW[0][0]);
    wr(12'h236, 32'h12345678);
    wr(12'h231, 32'h0000001F);
    chk("R11 idx kept", 32'(slot_idx), 10);
    wr(12'h235, TW[0][1]);
    @(negedge clk);
    wr(12'h234, TW[0][2]);
    chk_slot("R11 slot", 10, TE[0][0], TE[0][1], TE[0][2], TE[0][3]);
    chk("R11 idx", 32'(slot_idx), 11);

    // R2, R7, R8, R9: fill slot 15, then overflow
    wr(12'h232, 32'd15);
    for (int j = 0; j < 3; j++) wr(12'h233, TW[1][j]);
    chk("R8 idx 16", 32'(slot_idx), 16);
    chk_slot("R7 slot15", 15, TE[1][0], TE[1][1], TE[1][2], TE[1][3]);
    for (int j = 0; j < 3; j++) wr(12'h233, TW[2][j]);
    chk("R7 err pulse", 32'(err_o), 1);
    chk("R9 idx kept", 32'(slot_idx), 16);
    @(negedge clk);
    chk("R7 err single", 32'(err_o), 0);
    chk_slot("R9 slot15 kept", 15, TE[1][0], TE[1][1], TE[1][2], TE[1][3]);
    chk_slot("R9 slot0 kept", 0, TE[0][0], TE[0][1], TE[0][2], TE[0][3]);
    // R2 R9: count cleared after the rejection, so a fresh triple lands whole
    wr(12'h232, 32'd31);
    for (int j = 0; j < 3; j++) wr(12'h235, TW[3][j]);
    chk("R7 err idx 31", 32'(err_o), 1);
    wr(12'h232, 32'd4);
    for (int j = 0; j < 3; j++) wr(12'h233, TW[3][j]);
    chk("R2 no err", 32'(err_o), 0);
    chk_slot("R2 slot4", 4, TE[3][0], TE[3][1], TE[3][2], TE[3][3]);

    // R12: reset clears everything again
    wr(12'h233, 32'hAAAAAAAA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R12 idx again", 32'(slot_idx), 0);
    for (int s = 0; s < 16; s++) chk_slot("R12 again", s, 0, 0, 0, 0);
    for (int j = 0; j < 3; j++) wr(12'h233, TW[0][j]);
    chk_slot("R12 count cleared", 0, TE[0][0], TE[0][1], TE[0][2], TE[0][3]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule